// File: doc/BRIEF.md
# Configurable SPI Slave Receiver

This block is an SPI slave port that runs entirely on the system clock. The serial clock, slave-select and MOSI lines are brought into the system-clock domain through short synchroniser chains. Serial-clock edges are then detected there as single-cycle events. An 8-bit configuration register chooses, at run time, the clock polarity, the clock phase, the active level of slave select, and whether a character holds 8 or 16 bits. Characters travel most significant bit first in both directions.

Software uses a small word-wide register port with four addresses. It writes the configuration and the next word to transmit, and it reads the received character and a status word. When a whole character has arrived, the character is copied into a holding register and a receive-complete flag is set. If interrupts are enabled, an interrupt line is raised as well. Reading the holding register releases both. A character that lands while the flag is still set raises an overrun bit. Mode changes are deferred until slave select is inactive, so a character in flight is never corrupted by a reconfiguration.

Top module: `cfgSpiSlave`

## Requirements
- R1: Register address 0 holds the configuration. Bit 0 is clock polarity, bit 1 is clock phase, bit 2 is character width (1 = 16 bits), bit 6 is slave-select level (1 = active high) and bit 7 is interrupt enable. All bits reset to 0. Bits 5:3 and all bits above 7 ignore writes and read back as 0.
- R2: The slave is selected only while the synchronised slave-select pin equals bit 6 of the configuration. Serial clock edges seen while it is not selected receive nothing, and MISO output enable stays low.
- R3: A character is 8 bits when bit 2 is 0 and 16 bits when it is 1, received MSB first. An 8-bit character reads back in bits 7:0 of address 2, with the upper bits 0.
- R4: With clock polarity 0 the leading edge is the rising edge; with polarity 1 it is the falling edge. MOSI is sampled on the leading edge when clock phase is 0 and on the trailing edge when it is 1.
- R5: MISO sends the word written at address 1, MSB first (bit 7 for 8-bit characters, bit 15 for 16-bit ones), changing on the edge opposite the sampling edge. With clock phase 0 the first bit is present before the first clock edge. The output enable is high exactly while the slave is selected.
- R6: When a full character arrives, it is placed at address 2 and status bit 0 at address 3 is set. A read of address 2 clears status bits 0 and 1.
- R7: The interrupt output is high when status bit 0 is set and configuration bit 7 is 1. With bit 7 at 0 it stays low while the status bit still sets.
- R8: A character that completes while status bit 0 is already set sets status bit 1 (overrun) and replaces the held character.
- R9: Deselecting in the middle of a character discards the partial bits, sets no status, and restarts the bit count for the next selection.
- R10: Changes to bits 0, 1, 2 and 6 written while selected take effect only after deselection; the current character keeps the old width and timing. Reading address 0 returns the written value at once.
- R11: Several characters may follow each other within one selection. The transmit word is reloaded from address 1 at the drive edge after each character's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4 times the serial clock rate |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (read side effects) |
| regAddr | input | 2 | Register address: 0 config, 1 transmit, 2 receive, 3 status |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for the addressed register |
| sclkIn | input | 1 | Serial clock from the master |
| ssIn | input | 1 | Slave select from the master, level set by configuration |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for MISO, high while selected |
| irqOut | output | 1 | Receive interrupt |

## Verification
The hardest situations to reach from the ports are a character boundary inside one selection and a configuration write that lands halfway through a character. Both depend on where the bench's serial master is in its bit sequence, not on register timing alone. The bench master can pause mid-character. While paused, it rewrites the transmit word or the width bit, deselects after a partial character, or goes straight on into a second character. Randomly drawn modes, widths and data then cover all four clock modes against bench-computed expected words.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;

  localparam int SPI_DATA_W  = 16;
  localparam int SPI_SHORT_W = 8;
  localparam int SPI_ADDR_W  = 2;

  // Transfer mode: only updated while the slave is deselected.
  typedef struct packed {
    logic ssActiveHigh;
    logic wide;
    logic cpha;
    logic cpol;
  } mode_t;

  // Single-cycle events from control to datapath.
  typedef struct packed {
    logic load;    // copy transmit word into the shifter
    logic shift;   // advance MISO by one bit
    logic sample;  // capture one MOSI bit
    logic done;    // the sampled bit completes a character
  } strobe_t;

endpackage

// File: rtl/spi_slave_ctrl.sv
module spi_slave_ctrl
  import spi_slave_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LONG_BITS   = SPI_DATA_W,
  parameter int SHORT_BITS  = SPI_SHORT_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    ssIn,
  input  logic    mosiIn,
  input  mode_t   mode,
  output strobe_t stb,
  output logic    selActive,
  output logic    mosiBit
);

  localparam int CNT_W = $clog2(LONG_BITS);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_BITS - 1);

  // Synchronisers; the clock chain has one extra stage for edge detection.
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] ssPipe;
  logic [SYNC_STAGES-1:0] mosiPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      ssPipe   <= '1;
      mosiPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
      ssPipe   <= {ssPipe[SYNC_STAGES-2:0], ssIn};
      mosiPipe <= {mosiPipe[SYNC_STAGES-2:0], mosiIn};
    end
  end

  logic sclkNow, sclkOld, riseEdge, fallEdge;
  logic leadEdge, trailEdge, sampleEdge, driveEdge;
  logic selPrev, selStart, lastBit;
  logic [CNT_W-1:0] bitCnt;
  logic needLoad, skipFirst;

  assign sclkNow   = sclkPipe[SYNC_STAGES-1];
  assign sclkOld   = sclkPipe[SYNC_STAGES];
  assign riseEdge  = sclkNow & ~sclkOld;
  assign fallEdge  = ~sclkNow & sclkOld;
  assign leadEdge  = mode.cpol ? fallEdge : riseEdge;
  assign trailEdge = mode.cpol ? riseEdge : fallEdge;
  assign sampleEdge = mode.cpha ? trailEdge : leadEdge;
  assign driveEdge  = mode.cpha ? leadEdge : trailEdge;

  assign selActive = (ssPipe[SYNC_STAGES-1] == mode.ssActiveHigh);
  assign selStart  = selActive & ~selPrev;
  assign lastBit   = (bitCnt == (mode.wide ? LAST_LONG : LAST_SHORT));
  assign mosiBit   = mosiPipe[SYNC_STAGES-1];

  always_comb begin
    stb        = '0;
    stb.load   = selStart | (selActive & driveEdge & needLoad);
    stb.shift  = selActive & ~selStart & driveEdge & ~needLoad & ~skipFirst;
    stb.sample = selActive & ~selStart & sampleEdge;
    stb.done   = stb.sample & lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selPrev   <= 1'b0;
      bitCnt    <= '0;
      needLoad  <= 1'b0;
      skipFirst <= 1'b0;
    end else begin
      selPrev <= selActive;
      if (!selActive) begin
        bitCnt    <= '0;
        needLoad  <= 1'b0;
        skipFirst <= 1'b0;
      end else if (selStart) begin
        bitCnt    <= '0;
        needLoad  <= 1'b0;
        skipFirst <= mode.cpha;
      end else begin
        if (sampleEdge) begin
          bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
          if (lastBit) needLoad <= 1'b1;
        end
        if (driveEdge) begin
          skipFirst <= 1'b0;
          needLoad  <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/spi_slave_dp.sv
module spi_slave_dp
  import spi_slave_pkg::*;
#(
  parameter int DATA_W     = SPI_DATA_W,
  parameter int SHORT_BITS = SPI_SHORT_W,
  parameter int ADDR_W     = SPI_ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  strobe_t           stb,
  input  logic              selActive,
  input  logic              mosiBit,
  output mode_t             activeMode,
  output logic              misoOut,
  output logic              rxFull,
  output logic              overrun,
  output logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(3);
  localparam int IE_BIT = 7, SSPOL_BIT = 6, WIDE_BIT = 2, CPHA_BIT = 1, CPOL_BIT = 0;

  logic              ieReg;
  mode_t             modeShadow;
  logic [DATA_W-1:0] txData, txShift, holdReg;
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxNext, charOut;
  logic              rdRx;

  assign rdRx   = regRdEn && (regAddr == A_RXD);
  assign rxNext = {rxShift, mosiBit};
  assign charOut = activeMode.wide ? rxNext
                 : {{(DATA_W-SHORT_BITS){1'b0}}, rxNext[SHORT_BITS-1:0]};

  // Configuration and transmit word.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieReg      <= 1'b0;
      modeShadow <= '0;
      activeMode <= '0;
      txData     <= '0;
    end else begin
      if (regWrEn && regAddr == A_CFG) begin
        ieReg                   <= regWrData[IE_BIT];
        modeShadow.ssActiveHigh <= regWrData[SSPOL_BIT];
        modeShadow.wide         <= regWrData[WIDE_BIT];
        modeShadow.cpha         <= regWrData[CPHA_BIT];
        modeShadow.cpol         <= regWrData[CPOL_BIT];
      end
      if (regWrEn && regAddr == A_TXD) txData <= regWrData;
      if (!selActive) activeMode <= modeShadow;
    end
  end

  // Shifters, holding register and flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      holdReg <= '0;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.load)       txShift <= txData;
      else if (stb.shift) txShift <= {txShift[DATA_W-2:0], 1'b0};
      if (stb.sample) rxShift <= rxNext[DATA_W-2:0];
      if (stb.done) begin
        holdReg <= charOut;
        rxFull  <= 1'b1;
        overrun <= (overrun & ~rdRx) | (rxFull & ~rdRx);
      end else if (rdRx) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end
    end
  end

  assign misoOut = activeMode.wide ? txShift[DATA_W-1] : txShift[SHORT_BITS-1];
  assign irqOut  = rxFull & ieReg;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      A_CFG: begin
        regRdData[IE_BIT]    = ieReg;
        regRdData[SSPOL_BIT] = modeShadow.ssActiveHigh;
        regRdData[WIDE_BIT]  = modeShadow.wide;
        regRdData[CPHA_BIT]  = modeShadow.cpha;
        regRdData[CPOL_BIT]  = modeShadow.cpol;
      end
      A_TXD:  regRdData = txData;
      A_RXD:  regRdData = holdReg;
      A_STAT: regRdData[1:0] = {overrun, rxFull};
      default: regRdData = '0;
    endcase
  end

endmodule

// File: rtl/cfgSpiSlave.sv
module cfgSpiSlave
  import spi_slave_pkg::*;
#(
  parameter int DATA_W      = SPI_DATA_W,
  parameter int SHORT_BITS  = SPI_SHORT_W,
  parameter int ADDR_W      = SPI_ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              sclkIn,
  input  logic              ssIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              misoOe,
  output logic              irqOut
);

  strobe_t stb;
  mode_t   activeMode;
  logic    selActive, mosiBit, rxFull, overrun;

  spi_slave_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .LONG_BITS  (DATA_W),
    .SHORT_BITS (SHORT_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclkIn   (sclkIn),
    .ssIn     (ssIn),
    .mosiIn   (mosiIn),
    .mode     (activeMode),
    .stb      (stb),
    .selActive(selActive),
    .mosiBit  (mosiBit)
  );

  spi_slave_dp #(
    .DATA_W    (DATA_W),
    .SHORT_BITS(SHORT_BITS),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .stb       (stb),
    .selActive (selActive),
    .mosiBit   (mosiBit),
    .activeMode(activeMode),
    .misoOut   (misoOut),
    .rxFull    (rxFull),
    .overrun   (overrun),
    .irqOut    (irqOut)
  );

  assign misoOe = selActive;

endmodule

// File: rtl/spi_slave_chk.sv
module spi_slave_chk
  import spi_slave_pkg::*;
#(
  parameter int DATA_W = SPI_DATA_W,
  parameter int ADDR_W = SPI_ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input strobe_t           stb,
  input logic              selActive,
  input mode_t             activeMode,
  input logic              rxFull,
  input logic              overrun,
  input logic              irqOut
);

  // R1: reserved configuration bits always read as zero
  p_cfg_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (regRdData[5:3] == 3'b000 && (regRdData >> 8) == '0));

  // R6: a completed character leaves the flag set
  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> rxFull);

  // R6, R7: reading the receive word releases flag and interrupt
  p_rx_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_W'(2) && !stb.done) |=> (!rxFull && !irqOut && !overrun));

  // R7: the interrupt never stands without a pending character
  p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> rxFull);

  // R8: overrun only coexists with a pending character
  p_overrun_needs_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> rxFull);

  // R10: the transfer mode is frozen while selected
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    selActive |=> $stable(activeMode));

  // R9: no character completes outside a selection
  p_done_needs_select_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(selActive) |-> !stb.done);

endmodule

bind cfgSpiSlave spi_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regRdEn   (regRdEn),
  .regAddr   (regAddr),
  .regRdData (regRdData),
  .stb       (stb),
  .selActive (selActive),
  .activeMode(activeMode),
  .rxFull    (rxFull),
  .overrun   (overrun),
  .irqOut    (irqOut)
);

// File: tb/cfgSpiSlave_tb.sv
module cfgSpiSlave_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCK   = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        sclkPin = 1'b0, ssPin = 1'b1, mosiPin = 1'b0;
  logic        misoOut, misoOe, irqOut;

  logic mCpol = 0, mCpha = 0, mSspol = 0, mWide = 0, mIe = 0;
  int   checks = 0, errors = 0;
  bit   finished = 0;

  cfgSpiSlave u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .sclkIn(sclkPin), .ssIn(ssPin), .mosiIn(mosiPin),
    .misoOut(misoOut), .misoOe(misoOe), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] charMask(input logic wide, input logic [15:0] w);
    return wide ? w : {8'h00, w[7:0]};
  endfunction

  function automatic logic [15:0] cfgWord(input logic ie, sspol, wide, cpha, cpol);
    return {8'h00, ie, sspol, 3'b000, wide, cpha, cpol};
  endfunction

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regRdEn = 1'b0; regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setMode(input logic ie, sspol, wide, cpha, cpol);
    writeReg(2'd0, cfgWord(ie, sspol, wide, cpha, cpol));
    mIe = ie; mSspol = sspol; mWide = wide; mCpha = cpha; mCpol = cpol;
    ssPin = ~sspol; sclkPin = cpol;
    waitClk(8);
  endtask

  task automatic selectSlave();
    @(negedge clk);
    ssPin = mSspol;
    waitClk(6);
  endtask

  task automatic deselectSlave();
    waitClk(HALF_SCK);
    ssPin = ~mSspol;
    waitClk(6);
  endtask

  task automatic clockBits(input int topBit, input int count, input logic [15:0] mosiWord,
                           inout logic [15:0] misoAcc);
    for (int k = 0; k < count; k++) begin
      int i = topBit - k;
      if (!mCpha) begin
        mosiPin = mosiWord[i];
        waitClk(HALF_SCK);
        sclkPin = ~mCpol;
        misoAcc = {misoAcc[14:0], misoOut};
        waitClk(HALF_SCK);
        sclkPin = mCpol;
      end else begin
        sclkPin = ~mCpol;
        mosiPin = mosiWord[i];
        waitClk(HALF_SCK);
        sclkPin = mCpol;
        misoAcc = {misoAcc[14:0], misoOut};
        waitClk(HALF_SCK);
      end
    end
  endtask

  task automatic transfer(input logic [15:0] tx, input logic [15:0] mosiWord,
                          output logic [15:0] misoWord);
    logic [15:0] acc = '0;
    int nb = mWide ? 16 : 8;
    writeReg(2'd1, tx);
    selectSlave();
    clockBits(nb - 1, nb, mosiWord, acc);
    deselectSlave();
    misoWord = acc;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 0x%04h expected 0x%04h", 16'h0, 16'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, miso, acc, acc2;
    void'($urandom(32'd20240611));
    waitClk(3);
    rstN = 1'b1;
    waitClk(2);

    // R1: reset state of all registers and outputs
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d);
      check("R1 reset register", d, 16'h0000);
    end
    check("R5 reset misoOe", {15'b0, misoOe}, 16'h0);
    check("R7 reset irq", {15'b0, irqOut}, 16'h0);

    // R1: reserved bits ignore writes
    writeReg(2'd0, 16'hFFFF);
    peek(2'd0, d);
    check("R1 reserved bits read 0", d, 16'h00C7);
    setMode(0, 0, 0, 0, 0);

    // R3 R4 R5 R6 R7: mode 0, 8 bits, interrupt disabled
    writeReg(2'd1, 16'h12A5);
    selectSlave();
    check("R5 oe while selected", {15'b0, misoOe}, 16'h1);
    acc = '0;
    clockBits(7, 8, 16'h003C, acc);
    deselectSlave();
    check("R5 oe after deselect", {15'b0, misoOe}, 16'h0);
    check("R5 miso 8-bit", acc & 16'h00FF, 16'h00A5);
    peek(2'd3, d);
    check("R6 status set", d, 16'h0001);
    check("R7 no irq when disabled", {15'b0, irqOut}, 16'h0);
    readReg(2'd2, d);
    check("R3 rx 8-bit", d, 16'h003C);
    peek(2'd3, d);
    check("R6 status cleared by read", d, 16'h0000);

    // R3 R4 R7: mode 3, 16 bits, interrupt enabled
    setMode(1, 0, 1, 1, 1);
    transfer(16'hBEEF, 16'hC35A, miso);
    check("R5 miso 16-bit", miso, 16'hBEEF);
    check("R7 irq raised", {15'b0, irqOut}, 16'h1);
    readReg(2'd2, d);
    check("R3 rx 16-bit", d, 16'hC35A);
    check("R7 irq cleared by read", {15'b0, irqOut}, 16'h0);

    // R8: overrun
    transfer(16'h0001, 16'h1111, miso);
    transfer(16'h0002, 16'h2222, miso);
    peek(2'd3, d);
    check("R8 overrun status", d, 16'h0003);
    readReg(2'd2, d);
    check("R8 newer char kept", d, 16'h2222);
    peek(2'd3, d);
    check("R8 overrun cleared", d, 16'h0000);

    // R9: abort mid-character
    setMode(0, 0, 0, 1, 0);
    writeReg(2'd1, 16'h0081);
    selectSlave();
    acc = '0;
    clockBits(7, 3, 16'h00FF, acc);
    deselectSlave();
    peek(2'd3, d);
    check("R9 no status after abort", d, 16'h0000);
    transfer(16'h0066, 16'h0096, miso);
    readReg(2'd2, d);
    check("R9 clean char after abort", d, 16'h0096);
    check("R9 miso after abort", miso & 16'h00FF, 16'h0066);

    // R10: width change written mid-character is deferred
    setMode(0, 0, 0, 0, 0);
    writeReg(2'd1, 16'h5A5A);
    selectSlave();
    acc = '0;
    clockBits(7, 4, 16'h00C3, acc);
    writeReg(2'd0, cfgWord(0, 0, 1, 0, 0));
    peek(2'd0, d);
    check("R10 config reads new value", d, 16'h0004);
    clockBits(3, 4, 16'h00C3, acc);
    deselectSlave();
    readReg(2'd2, d);
    check("R10 old width kept", d, 16'h00C3);
    check("R10 miso old width", acc & 16'h00FF, 16'h005A);
    mWide = 1;
    transfer(16'h8001, 16'hF00D, miso);
    readReg(2'd2, d);
    check("R10 new width applied", d, 16'hF00D);
    check("R10 miso new width", miso, 16'h8001);

    // R11: back-to-back characters in one selection
    for (int ph = 0; ph < 2; ph++) begin
      setMode(0, 0, 0, 1'(ph), 1'(ph));
      writeReg(2'd1, 16'h00E1);
      selectSlave();
      acc = '0;
      clockBits(7, 4, 16'h0071, acc);
      writeReg(2'd1, 16'h003B);
      clockBits(3, 4, 16'h0071, acc);
      readReg(2'd2, d);
      check("R11 first char", d, 16'h0071);
      acc2 = '0;
      clockBits(7, 8, 16'h00D4, acc2);
      deselectSlave();
      readReg(2'd2, d);
      check("R11 second char", d, 16'h00D4);
      check("R11 miso first", acc & 16'h00FF, 16'h00E1);
      check("R11 miso second", acc2 & 16'h00FF, 16'h003B);
    end

    // R2: active-high select; wrong level receives nothing
    setMode(0, 1, 0, 0, 0);
    acc = '0;
    clockBits(7, 8, 16'h00FF, acc);
    check("R2 oe low when not selected", {15'b0, misoOe}, 16'h0);
    waitClk(HALF_SCK);
    peek(2'd3, d);
    check("R2 nothing received unselected", d, 16'h0000);
    transfer(16'h00C8, 16'h0017, miso);
    readReg(2'd2, d);
    check("R2 active-high select rx", d, 16'h0017);

    // R4 R3 R5 R7: random modes and data
    for (int it = 0; it < 24; it++) begin
      logic [4:0] r = 5'($urandom);
      logic [15:0] tx = 16'($urandom);
      logic [15:0] mo = 16'($urandom);
      setMode(r[4], r[3], r[2], r[1], r[0]);
      transfer(tx, mo, miso);
      check("R7 random irq", {15'b0, irqOut}, {15'b0, mIe});
      check("R5 random miso", charMask(mWide, miso), charMask(mWide, tx));
      readReg(2'd2, d);
      check("R4 random rx", d, charMask(mWide, mo));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule